// File: doc/BRIEF.md
# Butterfly Packet Switching Fabric

This block moves single-word packets between 2^D endpoints through a butterfly of D+1 ranks, each holding 2^D switch nodes. An endpoint offers a packet made of a destination address and a payload on a valid/ready handshake. The packet enters the rank-0 node in its own column and then moves down one rank per cycle. Each rank steers on one destination bit, most significant first. A node either keeps the packet in its column (the straight link) or moves it to the partner column whose bit for that rank is inverted (the cross link). The bit it consumed is shifted out of the address the packet carries.

Every node is a one-entry register. Two packets can want the same lower node in the same cycle. When that happens, the packet on the straight link is taken and the cross-link packet waits in place. The wait propagates upstream as back-pressure, so an endpoint sees its ready flag drop. Once a packet reaches the last rank, it is presented as a payload on the output port whose index equals its destination. That output uses its own valid/ready handshake.

Top module: `bflyRouter`

## Requirements
- R1: After reset every output valid is low and every input ready is high. Reset empties every node.
- R2: A packet accepted on input s with destination k (field inDest[s*DEST_W +: DEST_W]) appears exactly once on output k. Its payload is the payload given at input s.
- R3: On an uncontended path with output ready held high, a packet accepted at a clock edge is consumed at the output DEST_W+1 edges later. The packet passes one node per rank, DEST_W+1 nodes in all.
- R4: Rank r (1..DEST_W) node j is fed straight from rank r-1 node j, and across from rank r-1 node j XOR 2^(DEST_W-r). When both links request it in one cycle, the straight packet goes first and the cross packet follows exactly one cycle later.
- R5: While an output has valid high and ready low, valid stays high and the payload does not change.
- R6: An input ready is low only while its rank-0 node holds a packet that cannot move on. An offer made while ready is low is not taken.
- R7: Packets from one input to one output leave in the order they were accepted.
- R8: Under sustained output back-pressure the fabric loses nothing. A single blocked source-to-destination path absorbs exactly DEST_W+1 packets. Once the output is released, all queued packets are delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | N | Packet offered, one bit per endpoint |
| inReady | output | N | Rank-0 node can take the offer |
| inDest | input | N*DEST_W | Destination address per endpoint |
| inPayload | input | N*PAY_W | Payload per endpoint |
| outValid | output | N | Packet present at output endpoint |
| outReady | input | N | Output endpoint accepts the packet |
| outPayload | output | N*PAY_W | Payload per output endpoint |

## Verification
Arbitration and back-pressure can fall in the same cycle. A rank node is granted to its straight neighbour, and in that same cycle the cross neighbour's refusal ripples up and lowers an input ready. The bench provokes this with two packets injected together from columns 0 and 4 toward output 0. It judges the outcome by exact delivery cycles and by the ready level of the losing input one cycle after injection. Randomised output stalls combined with all-to-one traffic then check that every payload arrives once, in order, at its addressed port.

// File: rtl/bflyPkg.sv
package bflyPkg;
  // strobes from the control to one switch node of the datapath
  typedef struct packed {
    logic load;      // capture a new packet this cycle
    logic selCross;  // take it from the cross link rather than straight
    logic drain;     // the held packet moves on this cycle
  } nodeStrobe_t;
endpackage

// File: rtl/bflyDatapath.sv
module bflyDatapath
  import bflyPkg::*;
#(
  parameter int DEST_W = 3,
  parameter int PAY_W  = 8,
  localparam int N     = 1 << DEST_W,
  localparam int RANKS = DEST_W + 1,
  localparam int NODES = RANKS * N
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  nodeStrobe_t             strobes [NODES],
  input  logic [N*DEST_W-1:0]     inDest,
  input  logic [N*PAY_W-1:0]      inPayload,
  output logic [NODES-1:0]        nodeValid,
  output logic [DEST_W*N-1:0]     nodeMsb,
  output logic [N*PAY_W-1:0]      outPayload
);

  logic              validQ [NODES];
  logic [DEST_W-1:0] addrQ  [NODES];
  logic [PAY_W-1:0]  dataQ  [NODES];

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    for (genvar j = 0; j < N; j++) begin : g_col
      localparam int IDX = r * N + j;

      always_ff @(posedge clk) begin
        if (!rstN)                    validQ[IDX] <= 1'b0;
        else if (strobes[IDX].load)   validQ[IDX] <= 1'b1;
        else if (strobes[IDX].drain)  validQ[IDX] <= 1'b0;
      end

      if (r == 0) begin : g_entry
        always_ff @(posedge clk) begin
          if (strobes[IDX].load) begin
            addrQ[IDX] <= inDest[j*DEST_W +: DEST_W];
            dataQ[IDX] <= inPayload[j*PAY_W +: PAY_W];
          end
        end
      end else begin : g_inner
        localparam int MASK = 1 << (DEST_W - r);
        localparam int SIDX = (r - 1) * N + j;
        localparam int CIDX = (r - 1) * N + (j ^ MASK);
        logic [DEST_W-1:0] srcAddr;
        logic [PAY_W-1:0]  srcData;
        assign srcAddr = strobes[IDX].selCross ? addrQ[CIDX] : addrQ[SIDX];
        assign srcData = strobes[IDX].selCross ? dataQ[CIDX] : dataQ[SIDX];
        always_ff @(posedge clk) begin
          if (strobes[IDX].load) begin
            addrQ[IDX] <= srcAddr << 1;   // consumed bit leaves the top
            dataQ[IDX] <= srcData;
          end
        end
      end

      assign nodeValid[IDX] = validQ[IDX];

      if (r < DEST_W) begin : g_msb
        assign nodeMsb[IDX] = addrQ[IDX][DEST_W-1];
      end else begin : g_exit
        assign outPayload[j*PAY_W +: PAY_W] = dataQ[IDX];
      end
    end
  end

  // R1: the first cycle after reset sees an empty fabric
  p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (nodeValid == '0));

endmodule

// File: rtl/bflyControl.sv
module bflyControl
  import bflyPkg::*;
#(
  parameter int DEST_W = 3,
  localparam int N     = 1 << DEST_W,
  localparam int RANKS = DEST_W + 1,
  localparam int NODES = RANKS * N
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NODES-1:0]     nodeValid,
  input  logic [DEST_W*N-1:0]  nodeMsb,
  input  logic [N-1:0]         inValid,
  input  logic [N-1:0]         outReady,
  output nodeStrobe_t          strobes [NODES],
  output logic [N-1:0]         inReady
);

  logic [NODES-1:0] fireV;    // node hands its packet on this cycle
  logic [NODES-1:0] bothReq;  // node sees straight and cross requests together

  always_comb begin
    int   idx, sIdx, cIdx, m;
    logic colBit, room, sReq, cReq, sGnt, cGnt;
    fireV   = '0;
    bothReq = '0;
    inReady = '0;
    for (int i = 0; i < NODES; i++) strobes[i] = '0;

    // last rank drains into the output handshake
    for (int j = 0; j < N; j++)
      fireV[DEST_W*N + j] = nodeValid[DEST_W*N + j] && outReady[j];

    // walk from the bottom rank upward so room is known before grants
    for (int r = DEST_W; r >= 1; r--) begin
      for (int j = 0; j < N; j++) begin
        idx    = r * N + j;
        m      = 1 << (DEST_W - r);
        sIdx   = (r - 1) * N + j;
        cIdx   = (r - 1) * N + (j ^ m);
        colBit = ((j >> (DEST_W - r)) & 1) != 0;
        room   = !nodeValid[idx] || fireV[idx];
        // both neighbours address node j exactly when their next bit equals j's bit
        sReq   = nodeValid[sIdx] && (nodeMsb[sIdx] == colBit);
        cReq   = nodeValid[cIdx] && (nodeMsb[cIdx] == colBit);
        sGnt   = sReq && room;
        cGnt   = cReq && !sReq && room;
        fireV[sIdx] = fireV[sIdx] | sGnt;
        fireV[cIdx] = fireV[cIdx] | cGnt;
        bothReq[idx]          = sReq && cReq;
        strobes[idx].load     = sGnt || cGnt;
        strobes[idx].selCross = cGnt;
        strobes[idx].drain    = fireV[idx];
      end
    end

    for (int j = 0; j < N; j++) begin
      room               = !nodeValid[j] || fireV[j];
      inReady[j]         = room;
      strobes[j].load    = inValid[j] && room;
      strobes[j].drain   = fireV[j];
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_inChk
    // R6: refusal at an input only comes from an occupied entry node
    p_ready_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
      !inReady[j] |-> nodeValid[j]);
  end

  for (genvar r = 1; r < RANKS; r++) begin : g_arbChk
    for (genvar j = 0; j < N; j++) begin : g_col
      localparam int CIDX = (r - 1) * N + (j ^ (1 << (DEST_W - r)));
      // R4: the cross packet that lost arbitration is still held next cycle
      p_straight_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
        bothReq[r*N + j] |=> nodeValid[CIDX]);
    end
  end

endmodule

// File: rtl/bflyRouter.sv
module bflyRouter
  import bflyPkg::*;
#(
  parameter int DEST_W = 3,
  parameter int PAY_W  = 8,
  localparam int N     = 1 << DEST_W,
  localparam int NODES = (DEST_W + 1) * N
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [N-1:0]         inValid,
  output logic [N-1:0]         inReady,
  input  logic [N*DEST_W-1:0]  inDest,
  input  logic [N*PAY_W-1:0]   inPayload,
  output logic [N-1:0]         outValid,
  input  logic [N-1:0]         outReady,
  output logic [N*PAY_W-1:0]   outPayload
);

  nodeStrobe_t          strobes [NODES];
  logic [NODES-1:0]     nodeValid;
  logic [DEST_W*N-1:0]  nodeMsb;

  bflyControl #(.DEST_W(DEST_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .nodeValid(nodeValid),
    .nodeMsb  (nodeMsb),
    .inValid  (inValid),
    .outReady (outReady),
    .strobes  (strobes),
    .inReady  (inReady)
  );

  bflyDatapath #(.DEST_W(DEST_W), .PAY_W(PAY_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .inDest    (inDest),
    .inPayload (inPayload),
    .nodeValid (nodeValid),
    .nodeMsb   (nodeMsb),
    .outPayload(outPayload)
  );

  assign outValid = nodeValid[DEST_W*N +: N];

  for (genvar j = 0; j < N; j++) begin : g_outChk
    // R5: a stalled output keeps its packet unchanged
    p_out_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
      (outValid[j] && !outReady[j]) |=>
        (outValid[j] && $stable(outPayload[j*PAY_W +: PAY_W])));
  end

endmodule

// File: tb/test_bflyRouter.sv
module test_bflyRouter;
  localparam int D   = 3;
  localparam int W   = 8;
  localparam int N   = 1 << D;
  localparam int LAT = D + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]   inValid = '0;
  logic [N-1:0]   inReady;
  logic [N*D-1:0] inDest = '0;
  logic [N*W-1:0] inPayload = '0;
  logic [N-1:0]   outValid;
  logic [N-1:0]   outReady = '1;
  logic [N*W-1:0] outPayload;

  bflyRouter #(.DEST_W(D), .PAY_W(W)) i_bflyRouter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inDest(inDest), .inPayload(inPayload), .outValid(outValid),
    .outReady(outReady), .outPayload(outPayload)
  );

  int errors = 0, checks = 0, cyc = 0;
  int qDst [N][64];
  int qHead [N], qTail [N], curId [N];
  int expDst [256], expSrc [256], sentCyc [256], gotCyc [256];
  bit seen [256];
  int lastId [N][N];
  int nextId = 0, nDeliv = 0;
  logic [N-1:0] readyMask = '1;
  int readyMode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [N-1:0] lastInReady;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic resetPhase();
    for (int s = 0; s < N; s++) begin
      qHead[s] = 0; qTail[s] = 0; curId[s] = -1;
      for (int k = 0; k < N; k++) lastId[s][k] = -1;
    end
    for (int i = 0; i < 256; i++) seen[i] = 0;
    nextId = 0; nDeliv = 0;
  endtask

  task automatic push(input int s, input int d);
    qDst[s][qTail[s]] = d;
    qTail[s]++;
  endtask

  task automatic step();
    int id;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    outReady = readyMask & ((readyMode != 0) ? lfsr[N-1:0] : {N{1'b1}});
    for (int s = 0; s < N; s++) begin
      if (qHead[s] < qTail[s]) begin
        if (curId[s] < 0) begin
          curId[s] = nextId;
          expDst[nextId] = qDst[s][qHead[s]];
          expSrc[nextId] = s;
          nextId++;
        end
        inValid[s] = 1'b1;
        inDest[s*D +: D] = D'(qDst[s][qHead[s]]);
        inPayload[s*W +: W] = W'(curId[s]);
      end else begin
        inValid[s] = 1'b0;
      end
    end
    #1;
    lastInReady = inReady;
    for (int s = 0; s < N; s++) begin
      if (inValid[s] && inReady[s]) begin
        sentCyc[curId[s]] = cyc;
        qHead[s]++;
        curId[s] = -1;
      end
    end
    for (int k = 0; k < N; k++) begin
      if (outValid[k] && outReady[k]) begin
        id = int'(outPayload[k*W +: W]);
        chk(!seen[id] && id < nextId && expDst[id] == k, "R2 delivery port", k,
            (id < nextId) ? expDst[id] : -1);
        if (id < nextId) begin
          chk(id > lastId[expSrc[id]][k], "R7 order", id, lastId[expSrc[id]][k] + 1);
          lastId[expSrc[id]][k] = id;
        end
        seen[id] = 1;
        gotCyc[id] = cyc;
        nDeliv++;
      end
    end
    cyc++;
  endtask

  function automatic bit pending();
    for (int s = 0; s < N; s++) if (qHead[s] < qTail[s]) return 1;
    return 0;
  endfunction

  task automatic runPhase();
    int n = 0;
    while ((pending() || nDeliv < nextId) && n < 2000) begin
      step();
      n++;
    end
    chk(nDeliv == nextId && !pending(), "R8 all delivered", nDeliv, nextId);
  endtask

  initial begin
    logic [W-1:0] heldPay;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == '0, "R1 outValid after reset", int'(outValid), 0);
    chk(inReady == '1, "R1 inReady after reset", int'(inReady), (1 << N) - 1);

    // R3: every source/destination pair alone, fixed latency
    for (int s = 0; s < N; s++) begin
      for (int d = 0; d < N; d++) begin
        resetPhase();
        push(s, d);
        runPhase();
        chk(gotCyc[0] - sentCyc[0] == LAT, "R3 latency", gotCyc[0] - sentCyc[0], LAT);
      end
    end

    // R4: straight (col 0) and cross (col 4) both want rank-1 node 0
    resetPhase();
    push(0, 0);
    push(4, 0);
    step();
    chk(sentCyc[0] == sentCyc[1], "R4 same-cycle injection", sentCyc[1], sentCyc[0]);
    step();
    chk(lastInReady[4] == 1'b0, "R4 loser input stalled", int'(lastInReady[4]), 0);
    chk(lastInReady[0] == 1'b1, "R4 winner input free", int'(lastInReady[0]), 1);
    runPhase();
    chk(gotCyc[0] - sentCyc[0] == LAT, "R4 straight first", gotCyc[0] - sentCyc[0], LAT);
    chk(gotCyc[1] - sentCyc[1] == LAT + 1, "R4 cross one later", gotCyc[1] - sentCyc[1], LAT + 1);

    // R2/R7: xor permutations with free outputs
    readyMode = 0;
    for (int k = 0; k < N; k++) begin
      resetPhase();
      for (int s = 0; s < N; s++) for (int p = 0; p < 4; p++) push(s, s ^ k);
      runPhase();
    end

    // R2/R7: shift permutations with random output stalls
    readyMode = 1;
    for (int k = 0; k < N; k++) begin
      resetPhase();
      for (int s = 0; s < N; s++) for (int p = 0; p < 4; p++) push(s, (s + k) % N);
      runPhase();
    end

    // R8/R7: all sources to one hot output under stalls
    resetPhase();
    for (int s = 0; s < N; s++) for (int p = 0; p < 6; p++) push(s, 3);
    runPhase();

    // R5/R6/R8: output 6 blocked while source 1 streams to it
    readyMode = 0;
    readyMask = '1;
    readyMask[6] = 1'b0;
    resetPhase();
    for (int p = 0; p < 8; p++) push(1, 6);
    repeat (30) step();
    chk(qHead[1] == LAT, "R8 blocked path capacity", qHead[1], LAT);
    chk(nDeliv == 0, "R6 nothing passes a stalled output", nDeliv, 0);
    chk(lastInReady[1] == 1'b0, "R6 input refused when full", int'(lastInReady[1]), 0);
    heldPay = outPayload[6*W +: W];
    repeat (5) step();
    chk(outValid[6] == 1'b1, "R5 valid held", int'(outValid[6]), 1);
    chk(outPayload[6*W +: W] == heldPay, "R5 payload held", int'(outPayload[6*W +: W]), int'(heldPay));
    chk(qHead[1] == LAT, "R6 no extra accept while stalled", qHead[1], LAT);
    readyMask = '1;
    runPhase();
    chk(nDeliv == 8, "R8 released stream complete", nDeliv, 8);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      if (!done && cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

endmodule